// File: doc/BRIEF.md
# ADC conversion trigger selector

This block decides the clock cycle in which a multi-channel ADC controller launches a conversion sequence. Three things can start a sequence. The first is a software start strobe taken from a control-register write. The second is an asynchronous external trigger pin. The third is a 3-bit trigger mode that selects which pin edge, if any, counts as a trigger. The pin is passed through a synchroniser. The selected edge type is then detected, and the block sends a single-cycle start pulse to the conversion sequencer.

A software reset bit in the same control write returns the block to software-only operation. When a hardware edge arrives while the sequencer reports busy, the block sets a sticky overrun flag and does not queue a second start. The register bus decode, the sequencer and the analog core lie outside this block.

Top module: `adc_trig_sel`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `mode_o` is 0 and `start_pulse` and `overrun` are both low.
- R2: A control write (`ctl_we`=1) with bit 1 of `ctl_wdata` set and bit 0 clear drives `start_pulse` high for exactly the one cycle after the write edge. This holds in every trigger mode.
- R3: In mode 0, and in the unused modes 4 to 7, no level or edge on `ext_trig` ever produces a start pulse.
- R4: In mode 1, a rising edge of `ext_trig` produces one start pulse. If the new pin level is first sampled at clock edge k, the pulse is high between edges k+2 and k+3.
- R5: In mode 2, a falling edge of `ext_trig` produces one start pulse, with the same latency as R4.
- R6: In mode 3, each rising edge and each falling edge of `ext_trig` produces one start pulse, with the same latency as R4.
- R7: A mode write (`cfg_mode_we`=1) loads `cfg_mode` at the write edge, and the new mode appears on `mode_o` in the next cycle. A pin edge whose detection falls on the write edge itself is ignored. Switching modes while the pin is held steady causes no start.
- R8: A control write with bit 0 set is a software reset. It forces the mode to 0 and clears `overrun`, and it suppresses any start in that cycle. It takes priority over a start bit and over a simultaneous mode write.
- R9: A detected hardware edge while `seq_busy` is high gives no start pulse and sets `overrun`. `overrun` then stays set until a software reset.
- R10: A software start and a detected hardware edge on the same clock edge give a single one-cycle start pulse.
- R11: A software start is honoured while `seq_busy` is high, and it never sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 software reset, bit 1 start |
| cfg_mode_we | input | 1 | Trigger-mode field write strobe |
| cfg_mode | input | 3 | Trigger mode: 0 software only, 1 rising, 2 falling, 3 both edges |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| seq_busy | input | 1 | Sequencer is running a conversion sequence |
| start_pulse | output | 1 | One-cycle start request to the sequencer |
| overrun | output | 1 | Sticky flag: hardware trigger lost while busy |
| mode_o | output | 3 | Trigger mode currently in force |

## Verification
The bench times external edges so that detection lands exactly on a mode write. A design that compares the pin against stale history, or that uses the new mode in that cycle, would emit a stray start. It also lines up a software start with a hardware edge on the same edge, where a design that ORs two registered paths would send a two-cycle pulse. An edge during a busy window has to raise overrun and stay silent, so a design that queues the edge or clears the flag when busy falls would disagree with the per-cycle reference model. A combined reset, start and mode write shows whether the reset actually takes priority.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int TRG_MODE_W = 3;
  localparam int CTL_W      = 2;
  localparam int CTL_SRST_BIT  = 0;
  localparam int CTL_START_BIT = 1;

  typedef logic [TRG_MODE_W-1:0] trg_mode_t;

  localparam trg_mode_t TRG_SOFT = 3'd0;
  localparam trg_mode_t TRG_RISE = 3'd1;
  localparam trg_mode_t TRG_FALL = 3'd2;
  localparam trg_mode_t TRG_BOTH = 3'd3;

  // Decide whether the observed pin transition matches the selected mode.
  function automatic logic edge_hit(input trg_mode_t mode, input logic rise, input logic fall);
    logic hit;
    case (mode)
      TRG_RISE: hit = rise;
      TRG_FALL: hit = fall;
      TRG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trig_edge.sv
module trig_edge
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_sync,
  input  trg_mode_t mode,
  input  logic      mode_wr,
  output logic      hw_edge
);
  logic prev_q;
  logic rise, fall;

  // History follows the synchronised pin every cycle, so it is always
  // current when a new mode is loaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_sync;
  end

  assign rise    = pin_sync & ~prev_q;
  assign fall    = ~pin_sync & prev_q;
  assign hw_edge = edge_hit(mode, rise, fall) & ~mode_wr;
endmodule

// File: rtl/trig_mode_reg.sv
module trig_mode_reg
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      srst,
  input  logic      wr,
  input  trg_mode_t wdata,
  output trg_mode_t mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= TRG_SOFT;
    else if (srst) mode_q <= TRG_SOFT;
    else if (wr)   mode_q <= wdata;
  end
endmodule

// File: rtl/trig_start_ctl.sv
module trig_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic sw_start,
  input  logic hw_edge,
  input  logic busy,
  output logic start_q,
  output logic ovr_q
);
  logic hw_fire, hw_lost;

  assign hw_fire = hw_edge & ~busy;
  assign hw_lost = hw_edge & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (srst) begin
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      start_q <= sw_start | hw_fire;
      if (hw_lost) ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  cfg_mode_we,
  input  logic [TRG_MODE_W-1:0] cfg_mode,
  input  logic                  ext_trig,
  input  logic                  seq_busy,
  output logic                  start_pulse,
  output logic                  overrun,
  output logic [TRG_MODE_W-1:0] mode_o
);
  // Named internal events, visible to the bound checker.
  logic      srst_evt;
  logic      sw_start_evt;
  logic      hw_edge_evt;
  logic      pin_sync;
  trg_mode_t mode_q;

  assign srst_evt     = ctl_we & ctl_wdata[CTL_SRST_BIT];
  assign sw_start_evt = ctl_we & ctl_wdata[CTL_START_BIT] & ~srst_evt;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_trig),
    .dout (pin_sync)
  );

  trig_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .srst  (srst_evt),
    .wr    (cfg_mode_we),
    .wdata (cfg_mode),
    .mode_q(mode_q)
  );

  trig_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_sync(pin_sync),
    .mode    (mode_q),
    .mode_wr (cfg_mode_we | srst_evt),
    .hw_edge (hw_edge_evt)
  );

  trig_start_ctl u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_evt),
    .sw_start(sw_start_evt),
    .hw_edge (hw_edge_evt),
    .busy    (seq_busy),
    .start_q (start_pulse),
    .ovr_q   (overrun)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst_evt,
  input logic       sw_start_evt,
  input logic       hw_edge_evt,
  input logic       seq_busy,
  input logic       start_pulse,
  input logic       overrun,
  input logic [2:0] mode_o
);
  // R2
  sw_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start_evt |=> start_pulse);

  // R3
  soft_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mode_o inside {3'd1, 3'd2, 3'd3}) && !sw_start_evt) |=> !start_pulse);

  // R8
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_evt |=> (mode_o == 3'd0 && !overrun && !start_pulse));

  // R9
  busy_edge_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_edge_evt && seq_busy && !srst_evt) |=> overrun);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !srst_evt) |=> overrun);

  // R9
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(hw_edge_evt && seq_busy));

  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(sw_start_evt || hw_edge_evt));
endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .srst_evt    (srst_evt),
  .sw_start_evt(sw_start_evt),
  .hw_edge_evt (hw_edge_evt),
  .seq_busy    (seq_busy),
  .start_pulse (start_pulse),
  .overrun     (overrun),
  .mode_o      (mode_o)
);

// File: tb/sim_adc_trig_sel.sv
`timescale 1ns/1ps
module sim_adc_trig_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic       cfg_mode_we = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic       ext_trig = 1'b0;
  logic       seq_busy;
  logic       start_pulse, overrun;
  logic [2:0] mode_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  string cur_req = "R1";
  bit running = 1'b0;
  bit finished = 1'b0;

  // sequencer stub
  bit stub_en = 1'b0;
  int busy_len = 8;
  int busy_cnt = 0;
  assign seq_busy = (busy_cnt > 0);

  always #2.5 clk = ~clk;

  adc_trig_sel u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode), .ext_trig(ext_trig),
    .seq_busy(seq_busy), .start_pulse(start_pulse), .overrun(overrun), .mode_o(mode_o)
  );

  always @(posedge clk) begin
    if (stub_en && start_pulse) busy_cnt <= busy_len;
    else if (busy_cnt > 0)      busy_cnt <= busy_cnt - 1;
  end

  // behavioural reference model
  bit pin_hist[$] = '{1'b0, 1'b0};
  bit m_prev = 1'b0;
  int m_mode = 0;
  bit m_ovr = 1'b0;
  bit m_start = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_hist = '{1'b0, 1'b0};
      m_prev = 0; m_mode = 0; m_ovr = 0; m_start = 0;
    end else begin
      bit seen, up, down, hw, rst_w, sw;
      seen  = pin_hist[1];
      up    = seen && !m_prev;
      down  = !seen && m_prev;
      rst_w = ctl_we && ctl_wdata[0];
      sw    = ctl_we && ctl_wdata[1] && !rst_w;
      hw    = !cfg_mode_we && !rst_w &&
              ((m_mode == 1 && up) || (m_mode == 2 && down) || (m_mode == 3 && (up || down)));
      if (rst_w) begin
        m_mode = 0; m_ovr = 0; m_start = 0;
      end else begin
        m_start = sw || (hw && !seq_busy);
        if (hw && seq_busy) m_ovr = 1;
        if (cfg_mode_we) m_mode = int'(cfg_mode);
      end
      m_prev = seen;
      pin_hist.push_front(ext_trig);
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (start_pulse !== m_start || overrun !== m_ovr || int'(mode_o) != m_mode) begin
        errors++;
        $display("FAIL %s: start/ovr/mode actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 cur_req, start_pulse, overrun, mode_o, m_start, m_ovr, m_mode);
      end
      if (start_pulse) pulses++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [1:0] d);
    ctl_we = 1'b1; ctl_wdata = d; tick(1); ctl_we = 1'b0; ctl_wdata = 2'b00;
  endtask

  task automatic mode_write(input logic [2:0] m);
    cfg_mode_we = 1'b1; cfg_mode = m; tick(1); cfg_mode_we = 1'b0;
  endtask

  task automatic expect_count(input string req, input int base, input int want);
    checks++;
    if (pulses - base != want) begin
      errors++;
      $display("FAIL %s: pulse count actual %0d expected %0d", req, pulses - base, want);
    end
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      ext_trig = ~ext_trig; tick(6);
    end
  endtask

  initial begin
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    checks++;
    if (start_pulse !== 1'b0 || overrun !== 1'b0 || mode_o !== 3'd0) begin
      errors++;
      $display("FAIL R1: start/ovr/mode actual %0b/%0b/%0d expected 0/0/0", start_pulse, overrun, mode_o);
    end
    running = 1'b1;

    // R2 software start in mode 0
    cur_req = "R2"; base = pulses;
    ctl_write(2'b10); tick(3);
    expect_count("R2", base, 1);

    // R3 pin ignored in mode 0 and in an unused mode
    cur_req = "R3"; base = pulses;
    toggles(4);
    mode_write(3'd5); toggles(4);
    expect_count("R3", base, 0);

    // R4 rising edges
    cur_req = "R4"; mode_write(3'd1); tick(2); base = pulses;
    toggles(4);
    expect_count("R4", base, 2);

    // R5 falling edges
    cur_req = "R5"; mode_write(3'd2); tick(2); base = pulses;
    toggles(4);
    expect_count("R5", base, 2);

    // R6 both edges
    cur_req = "R6"; mode_write(3'd3); tick(2); base = pulses;
    toggles(4);
    expect_count("R6", base, 4);
    ctl_write(2'b10); tick(2);
    // R2 software start honoured in a hardware mode
    cur_req = "R2";

    // R7 mode switch with pin steady, then edge landing on a mode write
    cur_req = "R7"; base = pulses;
    mode_write(3'd0); tick(3);
    ext_trig = 1'b1; tick(6);
    mode_write(3'd1); tick(6);
    ext_trig = 1'b0; tick(2);
    mode_write(3'd2); tick(6);
    expect_count("R7", base, 0);

    // R9 edge during busy: no start, sticky overrun
    cur_req = "R9"; stub_en = 1'b1; busy_len = 12; mode_write(3'd1); tick(2); base = pulses;
    ctl_write(2'b10); tick(1);
    ext_trig = 1'b1; tick(20);
    expect_count("R9", base, 1);
    checks++;
    if (overrun !== 1'b1) begin
      errors++; $display("FAIL R9: overrun actual %0b expected 1", overrun);
    end

    // R11 software start while busy
    cur_req = "R11"; base = pulses;
    ctl_write(2'b10); tick(2);
    ctl_write(2'b10); tick(14);
    expect_count("R11", base, 2);
    stub_en = 1'b0; tick(14);

    // R10 software start and hardware edge on the same edge
    cur_req = "R10"; ext_trig = 1'b0; tick(6); base = pulses;
    ext_trig = 1'b1; tick(2);
    ctl_write(2'b10); tick(4);
    expect_count("R10", base, 1);

    // R8 soft reset beats start and mode write
    cur_req = "R8"; base = pulses;
    ctl_we = 1'b1; ctl_wdata = 2'b11; cfg_mode_we = 1'b1; cfg_mode = 3'd3;
    tick(1);
    ctl_we = 1'b0; ctl_wdata = 2'b00; cfg_mode_we = 1'b0;
    checks++;
    if (mode_o !== 3'd0 || overrun !== 1'b0 || start_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R8: start/ovr/mode actual %0b/%0b/%0d expected 0/0/0", start_pulse, overrun, mode_o);
    end
    toggles(4);
    expect_count("R8", base, 0);

    running = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule